// File: doc/BRIEF.md
# Data Cache Line State Controller

This block holds the coherence state of every line in a data cache and decides, for each access, the line's next state and which data movements the surrounding cache must carry out. It works for both copy-back and write-through memory regions. A mode bit arrives with each access, so regions of both kinds can share one cache. The block makes no data movement itself. The tag lookup supplies the line index and the hit flag, and the fill, write-back and store paths act on the strobes it raises.

The state of the addressed line and the decision derived from it are combinational. The stored state changes on the next rising clock edge, and only when the access strobe is high. A hit reported on a line that holds no data is flagged as a fault and has no effect on the line. An unknown command is treated the same way.

Top module: `dcl_line_ctrl`

## Requirements
- R1: Each line state is two bits {V,M}: invalid 2'b00, valid 2'b10, modified 2'b11. A synchronous active-low reset clears every line to invalid. Command codes on `acc_op` are: read 0, write 1, invalidate 2, push-and-invalidate 3, push-and-keep 4. `acc_copyback`=1 selects copy-back and 0 selects write-through. Outputs are combinational from the current inputs and the stored state, and the stored state takes `next_state` at the next rising edge when `acc_valid` is high.
- R2: A read miss raises fill and return and ends in valid. It also raises push when the old line is modified.
- R3: A read hit raises return only and leaves the state unchanged, whether the line is valid or modified.
- R4: A copy-back write miss raises fill and cache-write, plus push when the old line is modified, and ends in modified.
- R5: A write-through write miss raises memory-write only and keeps the state unchanged, including invalid (no allocation).
- R6: A copy-back write hit raises cache-write only and ends in modified.
- R7: A write-through write hit raises memory-write and cache-write and ends in valid, including from modified.
- R8: Invalidate raises no strobe and ends in invalid from any state. Modified data is dropped.
- R9: Push-and-invalidate raises push only when the line is modified and ends in invalid.
- R10: Push-and-keep raises push only when the line is modified. A modified or valid line ends valid, and an invalid line stays invalid.
- R11: A read or write reported as a hit on an invalid line, or a command code of 5 to 7, raises `err_illegal`, raises no other strobe and leaves the state unchanged.
- R12: With `acc_valid` low, no strobe and no error is raised and no line changes.
- R13: An access changes only the line selected by `acc_line`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Access strobe |
| acc_line | input | IDX_W (4) | Index of the line being accessed |
| acc_op | input | 3 | Command code |
| acc_hit | input | 1 | Tag lookup reported a hit |
| acc_copyback | input | 1 | 1 = copy-back region, 0 = write-through |
| line_state | output | 2 | Current state {V,M} of the addressed line |
| next_state | output | 2 | State the line will take on this access |
| act_fill | output | 1 | Read the line from memory into the cache |
| act_mem_write | output | 1 | Write the store data to memory |
| act_cache_write | output | 1 | Write the store data into the cache |
| act_push | output | 1 | Write the modified line back to memory |
| act_return | output | 1 | Return data to the processor |
| err_illegal | output | 1 | Illegal hit or command code |

## Verification
A wrong stored state stays hidden until the same line is accessed again. It then shows at once on `line_state`, and it changes the strobes of that access: a spurious or missing push, or a wrong fill. For this reason the bench revisits each line after every transition. It compares the full strobe set and both state outputs one cycle after each change. Idle cycles and accesses to neighbouring lines are followed by a revisit, which shows any change that should not have happened.

// File: rtl/dcl_pkg.sv
// Package: shared encodings for the data cache line state controller.
// Assumes state bit 1 is the valid bit and bit 0 the modified bit.
package dcl_pkg;

    typedef logic [1:0] line_st_t;

    localparam line_st_t ST_INV = 2'b00;
    localparam line_st_t ST_VAL = 2'b10;
    localparam line_st_t ST_MOD = 2'b11;

    typedef enum logic [2:0] {
        OP_READ      = 3'd0,
        OP_WRITE     = 3'd1,
        OP_INVAL     = 3'd2,
        OP_PUSH_INV  = 3'd3,
        OP_PUSH_KEEP = 3'd4
    } acc_op_t;

    typedef struct packed {
        logic fill;
        logic mem_write;
        logic cache_write;
        logic push;
        logic ret;
    } line_act_t;

endpackage

// File: rtl/dcl_next_decode.sv
// Module: dcl_next_decode
// Purely combinational transition table. From the current line state,
// the command, the hit flag and the region mode it gives the next state,
// the action set and an illegal flag. Assumes the caller gates the
// results with its own access strobe.
module dcl_next_decode
    import dcl_pkg::*;
(
    input  line_st_t  cur_state,
    input  logic [2:0] op,
    input  logic      hit,
    input  logic      copyback,
    output line_st_t  nxt_state,
    output line_act_t act,
    output logic      illegal
);

    logic is_valid;
    logic is_mod;

    assign is_valid = cur_state[1];
    assign is_mod   = (cur_state == ST_MOD);

    // Decide next state and strobes for one access.
    always_comb begin
        nxt_state = cur_state;
        act       = '0;
        illegal   = 1'b0;
        case (op)
            OP_READ: begin
                if (hit && !is_valid) begin
                    illegal = 1'b1;
                end else if (hit) begin
                    act.ret = 1'b1;
                end else begin
                    act.push  = is_mod;
                    act.fill  = 1'b1;
                    act.ret   = 1'b1;
                    nxt_state = ST_VAL;
                end
            end
            OP_WRITE: begin
                if (hit && !is_valid) begin
                    illegal = 1'b1;
                end else if (copyback) begin
                    act.cache_write = 1'b1;
                    nxt_state       = ST_MOD;
                    if (!hit) begin
                        act.push = is_mod;
                        act.fill = 1'b1;
                    end
                end else begin
                    act.mem_write = 1'b1;
                    if (hit) begin
                        act.cache_write = 1'b1;
                        nxt_state       = ST_VAL;
                    end
                end
            end
            OP_INVAL: begin
                nxt_state = ST_INV;
            end
            OP_PUSH_INV: begin
                act.push  = is_mod;
                nxt_state = ST_INV;
            end
            OP_PUSH_KEEP: begin
                act.push  = is_mod;
                nxt_state = is_valid ? ST_VAL : ST_INV;
            end
            default: begin
                illegal = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/dcl_state_store.sv
// Module: dcl_state_store
// Holds one two-bit state register per line, with one read port and one
// write port. Assumes at most one write per cycle. Reset is synchronous
// and active low, and clears every line to invalid.
module dcl_state_store
    import dcl_pkg::*;
#(
    parameter int LINES = 16,
    localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  line_st_t           wr_state,
    input  logic [IDX_W-1:0]   rd_idx,
    output line_st_t           rd_state,
    output logic [2*LINES-1:0] all_states
);

    line_st_t st_q [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        // Per-line register: reset to invalid, load on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_q[g] <= ST_INV;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                st_q[g] <= wr_state;
            end
        end
        assign all_states[2*g +: 2] = st_q[g];
    end

    // Read port: select the addressed line.
    assign rd_state = st_q[rd_idx];

endmodule

// File: rtl/dcl_line_ctrl.sv
// Module: dcl_line_ctrl (top)
// Data cache line state controller. It looks up the addressed line's
// state, decodes the transition and gates the result with acc_valid.
// The new state is committed at the next rising edge. Assumes acc_line
// is below LINES and that the inputs are stable around the edge.
module dcl_line_ctrl
    import dcl_pkg::*;
#(
    parameter int LINES = 16,
    localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_valid,
    input  logic [IDX_W-1:0] acc_line,
    input  logic [2:0]       acc_op,
    input  logic             acc_hit,
    input  logic             acc_copyback,
    output logic [1:0]       line_state,
    output logic [1:0]       next_state,
    output logic             act_fill,
    output logic             act_mem_write,
    output logic             act_cache_write,
    output logic             act_push,
    output logic             act_return,
    output logic             err_illegal
);

    line_st_t           cur_st;
    line_st_t           dec_nxt;
    line_act_t          dec_act;
    logic               dec_illegal;
    logic               commit;
    logic [2*LINES-1:0] st_flat;
    line_st_t           st_view [LINES];

    dcl_state_store #(.LINES(LINES)) store_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (commit),
        .wr_idx     (acc_line),
        .wr_state   (dec_nxt),
        .rd_idx     (acc_line),
        .rd_state   (cur_st),
        .all_states (st_flat)
    );

    dcl_next_decode decode_i (
        .cur_state (cur_st),
        .op        (acc_op),
        .hit       (acc_hit),
        .copyback  (acc_copyback),
        .nxt_state (dec_nxt),
        .act       (dec_act),
        .illegal   (dec_illegal)
    );

    // Commit only legal, strobed accesses.
    assign commit = acc_valid && !dec_illegal;

    // Drive outputs: strobes and error are gated by acc_valid.
    always_comb begin
        line_state      = cur_st;
        next_state      = commit ? dec_nxt : cur_st;
        act_fill        = commit && dec_act.fill;
        act_mem_write   = commit && dec_act.mem_write;
        act_cache_write = commit && dec_act.cache_write;
        act_push        = commit && dec_act.push;
        act_return      = commit && dec_act.ret;
        err_illegal     = acc_valid && dec_illegal;
    end

    for (genvar g = 0; g < LINES; g++) begin : g_view
        assign st_view[g] = st_flat[2*g +: 2];
    end

    // A read miss leaves the addressed line valid.
    assert_read_miss_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_op == OP_READ && !acc_hit)
        |=> st_view[$past(acc_line)] == ST_VAL);

    // A write-through miss never allocates and always writes memory.
    assert_wt_miss_no_alloc_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_op == OP_WRITE && !acc_copyback && !acc_hit)
        |-> (!act_fill && act_mem_write && !act_cache_write));

    // A push is only issued for a line that currently holds modified data.
    assert_push_needs_mod_R9: assert property (@(posedge clk) disable iff (!rst_n)
        act_push |-> (line_state == ST_MOD));

    // An illegal access leaves the line unchanged.
    assert_illegal_keeps_state_R11: assert property (@(posedge clk) disable iff (!rst_n)
        err_illegal |=> $stable(st_flat));

    // Idle cycles leave every line unchanged.
    assert_idle_no_change_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> $stable(st_flat));

    // A fill is never requested for a hit.
    assert_fill_only_miss_R4: assert property (@(posedge clk) disable iff (!rst_n)
        act_fill |-> !acc_hit);

endmodule

// File: tb/dcl_line_ctrl_tb_top.sv
module dcl_line_ctrl_tb_top;
    import dcl_pkg::*;

    localparam int LINES = 16;
    localparam int IDX_W = 4;

    typedef struct {
        logic [10:0] vec;   // {fill,memw,cachew,push,ret,err,line_state,next_state}
        string       tag;
    } exp_item_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             acc_valid = 1'b0;
    logic [IDX_W-1:0] acc_line = '0;
    logic [2:0]       acc_op = 3'd0;
    logic             acc_hit = 1'b0;
    logic             acc_copyback = 1'b0;
    logic [1:0]       line_state, next_state;
    logic             act_fill, act_mem_write, act_cache_write, act_push, act_return, err_illegal;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    exp_item_t sb_q[$];
    logic [1:0] model [LINES];

    always #2.5 clk = ~clk;

    dcl_line_ctrl #(.LINES(LINES)) dut_i (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_line(acc_line),
        .acc_op(acc_op), .acc_hit(acc_hit), .acc_copyback(acc_copyback),
        .line_state(line_state), .next_state(next_state), .act_fill(act_fill),
        .act_mem_write(act_mem_write), .act_cache_write(act_cache_write),
        .act_push(act_push), .act_return(act_return), .err_illegal(err_illegal)
    );

    // Driver: compute the expected result from the requirements, queue it, drive the inputs.
    task automatic access(input int line, input logic [2:0] op, input logic hit,
                          input logic cb, input logic vld, input string tag);
        logic [1:0] cur, nxt;
        logic f, mw, cw, p, r, e;
        exp_item_t it;
        @(negedge clk);
        cur = model[line];
        nxt = cur; f = 0; mw = 0; cw = 0; p = 0; r = 0; e = 0;
        if (vld) begin
            if ((op == 3'd0 || op == 3'd1) && hit && cur == 2'b00) e = 1;
            else if (op > 3'd4) e = 1;
            else if (op == 3'd0) begin
                r = 1;
                if (!hit) begin f = 1; p = (cur == 2'b11); nxt = 2'b10; end
            end else if (op == 3'd1 && cb) begin
                cw = 1; nxt = 2'b11;
                if (!hit) begin f = 1; p = (cur == 2'b11); end
            end else if (op == 3'd1) begin
                mw = 1;
                if (hit) begin cw = 1; nxt = 2'b10; end
            end else if (op == 3'd2) nxt = 2'b00;
            else if (op == 3'd3) begin p = (cur == 2'b11); nxt = 2'b00; end
            else begin p = (cur == 2'b11); nxt = (cur == 2'b00) ? 2'b00 : 2'b10; end
            if (!e) model[line] = nxt;
        end
        it.vec = {f, mw, cw, p, r, e, cur, nxt};
        it.tag = tag;
        sb_q.push_back(it);
        acc_valid = vld; acc_line = IDX_W'(line); acc_op = op;
        acc_hit = hit; acc_copyback = cb;
    endtask

    // Monitor: between negedge and posedge, pop one expectation and compare.
    always begin
        @(negedge clk);
        #1.5;
        if (sb_q.size() > 0) begin
            exp_item_t it;
            logic [10:0] act;
            it = sb_q.pop_front();
            act = {act_fill, act_mem_write, act_cache_write, act_push, act_return,
                   err_illegal, line_state, next_state};
            checks++;
            if (act !== it.vec) begin
                failures++;
                $display("FAIL %s actual=%b expected=%b", it.tag, act, it.vec);
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #200000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < LINES; i++) model[i] = 2'b00;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R1: reset state, observed with no access
        for (int i = 0; i < 4; i++) access(i, 3'd0, 0, 0, 0, "R1 reset invalid");
        access(15, 3'd0, 0, 0, 0, "R1 reset invalid");
        // line 0: read paths
        access(0, 3'd0, 0, 1, 1, "R2 read miss invalid");
        access(0, 3'd0, 1, 1, 1, "R3 read hit valid");
        access(0, 3'd1, 1, 1, 1, "R6 cb write hit valid");
        access(0, 3'd0, 1, 0, 1, "R3 read hit modified");
        access(0, 3'd0, 0, 1, 1, "R2 read miss modified push");
        access(0, 3'd0, 1, 1, 1, "R2 ended valid");
        // line 1: write and push paths
        access(1, 3'd1, 0, 1, 1, "R4 cb write miss invalid");
        access(1, 3'd1, 0, 1, 1, "R4 cb write miss modified push");
        access(1, 3'd1, 1, 0, 1, "R7 wt write hit modified");
        access(1, 3'd1, 1, 0, 1, "R7 wt write hit valid");
        access(1, 3'd1, 0, 0, 1, "R5 wt write miss valid");
        access(1, 3'd1, 1, 1, 1, "R6 cb write hit to modified");
        access(1, 3'd1, 0, 0, 1, "R5 wt write miss modified");
        access(1, 3'd4, 0, 1, 1, "R10 push keep modified");
        access(1, 3'd4, 0, 1, 1, "R10 push keep valid");
        access(1, 3'd3, 0, 1, 1, "R9 push inv valid");
        access(1, 3'd3, 0, 1, 1, "R9 push inv invalid");
        access(1, 3'd4, 0, 1, 1, "R10 push keep invalid");
        access(1, 3'd1, 0, 1, 1, "R4 cb write miss again");
        access(1, 3'd3, 0, 1, 1, "R9 push inv modified");
        access(1, 3'd0, 0, 1, 1, "R9 ended invalid");
        // line 2: no-allocate, illegal, invalidate
        access(2, 3'd1, 0, 0, 1, "R5 wt write miss invalid");
        access(2, 3'd0, 1, 1, 1, "R11 read hit invalid");
        access(2, 3'd1, 1, 1, 1, "R11 write hit invalid");
        access(2, 3'd5, 0, 1, 1, "R11 op code 5");
        access(2, 3'd1, 0, 1, 1, "R4 cb write miss after illegal");
        access(2, 3'd7, 0, 1, 1, "R11 op code 7 on modified");
        access(2, 3'd2, 0, 1, 1, "R8 invalidate modified");
        access(2, 3'd2, 0, 1, 1, "R8 invalidate invalid");
        access(2, 3'd0, 0, 0, 1, "R8 ended invalid");
        access(2, 3'd2, 0, 0, 1, "R8 invalidate valid");
        access(2, 3'd0, 1, 0, 1, "R11 read hit after invalidate");
        // line 3: idle cycles; lines 4/5: independence
        access(3, 3'd0, 0, 1, 1, "R2 read miss line3");
        access(3, 3'd1, 1, 1, 0, "R12 idle write hit");
        access(3, 3'd2, 0, 1, 0, "R12 idle invalidate");
        access(3, 3'd0, 1, 1, 1, "R12 line3 still valid");
        access(4, 3'd1, 0, 1, 1, "R13 write line4");
        access(3, 3'd0, 1, 1, 1, "R13 line3 untouched");
        access(5, 3'd0, 0, 0, 0, "R13 line5 untouched");
        access(15, 3'd0, 0, 0, 1, "R13 last line read miss");
        access(14, 3'd0, 0, 0, 0, "R13 line14 untouched");
        access(15, 3'd0, 1, 0, 1, "R13 last line valid");
        // Flush the queue.
        @(negedge clk);
        acc_valid = 1'b0;
        wait (sb_q.size() == 0);
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule